// File: doc/BRIEF.md
# BCD Year Counter with Leap-Year Flag

This block is the year stage of a calendar clock. It stores the year as four packed BCD digits, from 0000 to 9999. The count goes up by one on each year-carry pulse that the month stage sends, but only while the run enable is high. Software may read the value at any time. It may load a new value through a 16-bit write bus and strobe, but only while counting is halted.

The block also supplies a leap-year flag to the day and month logic. The flag is decoded directly from the two low BCD digits. It is set whenever the year is a multiple of four, with no exception for centuries. The value 0000 counts as a leap year.

No reset touches the stored year. The register keeps its contents until a halted write or a count changes it. Before the first write its contents are undefined.

Top module: `yr_bcd_counter`

## Requirements
- R1: Digit layout: bits 15..12 of the value are thousands, 11..8 hundreds, 7..4 tens and 3..0 units. Each digit is a 4-bit BCD code from 0 to 9. The stored value appears on `year_o` exactly as written.
- R2: A `yr_carry_i` pulse sampled high while `run_en_i` is high raises the year by exactly one. The new value appears on `year_o` after that clock edge.
- R3: A digit at 9 that receives an increment becomes 0 and carries into the next higher digit (for example 0009→0010, 0099→0100, 0999→1000).
- R4: Incrementing 9999 gives 0000.
- R5: A `yr_carry_i` pulse is ignored while `run_en_i` is low, and the value stays unchanged.
- R6: When `wr_stb_i` is high and `run_en_i` is low, `wr_data_i` is stored and appears on `year_o` after that clock edge.
- R7: When `wr_stb_i` is high and `run_en_i` is high, the write is ignored. A carry pulse in the same cycle still counts.
- R8: `leap_o` is high exactly when the year is divisible by four. It is true for 0000 and for century years such as 1900. It follows `year_o` with no extra cycle.
- R9: With no carry pulse and no accepted write, the value holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| yr_carry_i | input | 1 | One-cycle year-carry pulse from the month stage |
| run_en_i | input | 1 | High: counting enabled and writes blocked; low: halted, writes allowed |
| wr_stb_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Packed BCD year to load |
| year_o | output | 16 | Current packed BCD year |
| leap_o | output | 1 | Leap-year flag for the current year |

## Verification
Counting is exercised in several ways:
- From loaded values ending in each digit pattern that ripples a carry one, two, three and four digits deep. This separates a correct ripple from one that stops early or wraps the wrong digit.
- A long sweep of consecutive carries through a century boundary. Every residue of the year modulo four meets every tens parity, which exposes a wrong leap decode and any century exception.
- Carries while halted, writes while running, and cycles with a write and a carry together. These show whether the arbitration between loading and counting is correct.

// File: rtl/yr_pkg.sv
package yr_pkg;
    localparam int unsigned BCD_W     = 4;
    localparam int unsigned YR_DIGITS = 4;
    localparam int unsigned YR_W      = BCD_W * YR_DIGITS;
    localparam int unsigned TENS_IDX  = 1;
    localparam int unsigned UNITS_IDX = 0;

    typedef logic [BCD_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t [YR_DIGITS-1:0] digits;
    } yr_state_t;
endpackage

// File: rtl/yr_bcd_digit.sv
module yr_bcd_digit
    import yr_pkg::*;
(
    input  bcd_t cur_i,
    input  logic cin_i,
    output bcd_t nxt_o
);
    localparam bcd_t TOP_DIGIT = bcd_t'(9);

    always_comb begin
        nxt_o = cur_i;
        if (cin_i) begin
            if (cur_i >= TOP_DIGIT) nxt_o = '0;
            else                    nxt_o = cur_i + bcd_t'(1);
        end
    end
endmodule

// File: rtl/yr_bcd_incr.sv
module yr_bcd_incr
    import yr_pkg::*;
#(
    parameter int unsigned NDIG = YR_DIGITS
) (
    input  bcd_t [NDIG-1:0] cur_i,
    output bcd_t [NDIG-1:0] nxt_o
);
    localparam bcd_t TOP_DIGIT = bcd_t'(9);

    logic [NDIG-1:0] cin;

    assign cin[0] = 1'b1;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        if (g > 0) begin : g_chain
            assign cin[g] = cin[g-1] & (cur_i[g-1] >= TOP_DIGIT);
        end
        yr_bcd_digit u_digit (
            .cur_i (cur_i[g]),
            .cin_i (cin[g]),
            .nxt_o (nxt_o[g])
        );
    end
endmodule

// File: rtl/yr_leap_detect.sv
module yr_leap_detect
    import yr_pkg::*;
(
    input  logic tens_odd_i,
    input  bcd_t units_i,
    output logic leap_o
);
    logic units_mult4;
    logic units_2mod4;

    always_comb begin
        units_mult4 = (units_i == bcd_t'(0)) || (units_i == bcd_t'(4)) ||
                      (units_i == bcd_t'(8));
        units_2mod4 = (units_i == bcd_t'(2)) || (units_i == bcd_t'(6));
        leap_o      = tens_odd_i ? units_2mod4 : units_mult4;
    end
endmodule

// File: rtl/yr_bcd_counter.sv
module yr_bcd_counter
    import yr_pkg::*;
(
    input  logic            clk,
    input  logic            yr_carry_i,
    input  logic            run_en_i,
    input  logic            wr_stb_i,
    input  logic [YR_W-1:0] wr_data_i,
    output logic [YR_W-1:0] year_o,
    output logic            leap_o
);
    yr_state_t st_d, st_q;
    bcd_t [YR_DIGITS-1:0] inc_digits;

    yr_bcd_incr #(.NDIG(YR_DIGITS)) u_incr (
        .cur_i (st_q.digits),
        .nxt_o (inc_digits)
    );

    always_comb begin
        st_d = st_q;
        if (!run_en_i) begin
            if (wr_stb_i) st_d.digits = wr_data_i;
        end else if (yr_carry_i) begin
            st_d.digits = inc_digits;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    yr_leap_detect u_leap (
        .tens_odd_i (st_q.digits[TENS_IDX][0]),
        .units_i    (st_q.digits[UNITS_IDX]),
        .leap_o     (leap_o)
    );

    assign year_o = st_q.digits;
endmodule

// File: rtl/yr_bcd_counter_chk.sv
module yr_bcd_counter_chk
    import yr_pkg::*;
(
    input logic            clk,
    input logic            yr_carry_i,
    input logic            run_en_i,
    input logic            wr_stb_i,
    input logic [YR_W-1:0] wr_data_i,
    input logic [YR_W-1:0] year_o,
    input logic            leap_o
);
    logic armed_q = 1'b0;

    always_ff @(posedge clk) begin
        if (wr_stb_i && !run_en_i) armed_q <= 1'b1;
    end

    function automatic int unsigned to_bin(input logic [YR_W-1:0] v);
        int unsigned acc = 0;
        for (int i = YR_DIGITS - 1; i >= 0; i--) begin
            acc = acc * 10 + int'(v[i*BCD_W +: BCD_W]);
        end
        return acc;
    endfunction

    // R2, R3
    a_r2_count_step: assert property (@(posedge clk) disable iff (!armed_q)
        (run_en_i && yr_carry_i) |=> (to_bin(year_o) == (to_bin($past(year_o)) + 1) % 10000));

    a_r4_wrap: assert property (@(posedge clk) disable iff (!armed_q)
        (run_en_i && yr_carry_i && year_o == 16'h9999) |=> (year_o == 16'h0000));

    a_r5_halt_hold: assert property (@(posedge clk) disable iff (!armed_q)
        (!run_en_i && !wr_stb_i) |=> $stable(year_o));

    a_r6_load: assert property (@(posedge clk) disable iff (!armed_q)
        (!run_en_i && wr_stb_i) |=> (year_o == $past(wr_data_i)));

    // R7, R9
    a_r7_run_no_write: assert property (@(posedge clk) disable iff (!armed_q)
        (run_en_i && !yr_carry_i) |=> $stable(year_o));

    a_r8_leap: assert property (@(posedge clk) disable iff (!armed_q)
        leap_o == ((to_bin(year_o) % 4) == 0));
endmodule

bind yr_bcd_counter yr_bcd_counter_chk u_chk (
    .clk        (clk),
    .yr_carry_i (yr_carry_i),
    .run_en_i   (run_en_i),
    .wr_stb_i   (wr_stb_i),
    .wr_data_i  (wr_data_i),
    .year_o     (year_o),
    .leap_o     (leap_o)
);

// File: tb/yr_bcd_counter_tb.sv
module yr_bcd_counter_tb;
    logic        clk = 1'b0;
    logic        yr_carry_i = 1'b0;
    logic        run_en_i = 1'b0;
    logic        wr_stb_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] year_o;
    logic        leap_o;

    always #10 clk = ~clk;

    yr_bcd_counter u_dut (
        .clk        (clk),
        .yr_carry_i (yr_carry_i),
        .run_en_i   (run_en_i),
        .wr_stb_i   (wr_stb_i),
        .wr_data_i  (wr_data_i),
        .year_o     (year_o),
        .leap_o     (leap_o)
    );

    typedef struct {
        logic [15:0] year;
        logic        leap;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   model  = 0;
    bit   done   = 0;

    function automatic logic [15:0] to_bcd(input int v);
        return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic int from_bcd(input logic [15:0] b);
        return int'(b[15:12]) * 1000 + int'(b[11:8]) * 100 + int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    task automatic do_op(input bit carry, input bit run, input bit wr,
                         input logic [15:0] data, input string tag);
        exp_t e;
        @(posedge clk);
        #6;
        yr_carry_i = carry;
        run_en_i   = run;
        wr_stb_i   = wr;
        wr_data_i  = data;
        if (!run && wr)        model = from_bcd(data);
        else if (run && carry) model = (model + 1) % 10000;
        e.year = to_bcd(model);
        e.leap = (model % 4) == 0;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #3;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (year_o !== e.year) begin
                errors++;
                $display("FAIL %s year: actual %h expected %h", e.tag, year_o, e.year);
            end
            checks++;
            if (leap_o !== e.leap) begin
                errors++;
                $display("FAIL %s leap (year %h): actual %b expected %b", e.tag, year_o, leap_o, e.leap);
            end
        end
    end

    initial begin
        // R6 initial load of 0000 (no reset defines the state); R8 0000 is leap
        do_op(0, 0, 1, 16'h0000, "R6_R8_zero");
        do_op(0, 0, 0, 16'h0000, "R9_hold_halted");
        // R5 carry ignored while halted
        do_op(1, 0, 0, 16'h0000, "R5_carry_halted");
        // R2 count while running
        do_op(1, 1, 0, 16'h0000, "R2_step");
        do_op(0, 1, 0, 16'h0000, "R9_hold_running");
        // R7 write while running ignored, then write+carry counts
        do_op(0, 1, 1, 16'h5555, "R7_write_running");
        do_op(1, 1, 1, 16'h7777, "R7_write_and_carry");
        // R1 layout
        do_op(0, 0, 1, 16'h1234, "R1_layout");
        do_op(1, 1, 0, 16'h0000, "R1_units_low");
        // R3 ripple depths
        do_op(0, 0, 1, 16'h0009, "R3_load");
        do_op(1, 1, 0, 16'h0000, "R3_tens");
        do_op(0, 0, 1, 16'h0099, "R3_load");
        do_op(1, 1, 0, 16'h0000, "R3_hundreds");
        do_op(0, 0, 1, 16'h0999, "R3_load");
        do_op(1, 1, 0, 16'h0000, "R3_thousands");
        // R4 wrap
        do_op(0, 0, 1, 16'h9998, "R4_load");
        do_op(1, 1, 0, 16'h0000, "R4_to_9999");
        do_op(1, 1, 0, 16'h0000, "R4_wrap");
        // R8 century without exception, and sweep
        do_op(0, 0, 1, 16'h1896, "R8_load");
        for (int i = 0; i < 120; i++) do_op(1, 1, 0, 16'h0000, "R8_sweep");
        do_op(0, 0, 1, 16'h2024, "R6_load_2024");
        do_op(1, 0, 1, 16'h2031, "R5_R6_write_with_carry");
        do_op(0, 1, 0, 16'h0000, "R9_idle");
        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule